// File: doc/BRIEF.md
# Configurable LFSR Pattern Generator

This block produces pseudo-random test patterns with a linear feedback shift register of order `WIDTH`. Its feedback follows a characteristic polynomial `P(x) = c0 + c1·x + … + cn·x^n`, with the coefficients taken modulo two. The caller supplies the coefficients c0 through c(n-1) in a parameter, and cn is always one. With a primitive polynomial, the register steps through every nonzero state once before it repeats.

Two parameters choose one of four register structures for the same polynomial. `FORM` places the XOR gates either outside the chain, as one parity tree feeding the top stage, or between stages, one gate per nonzero coefficient. `RECIPROCAL` swaps the polynomial for its reciprocal `x^n·P(1/x)`, which is primitive whenever `P` is.

A caller uses the block by holding `en` high to advance one state per clock. Pulsing `load` writes a new starting value from `seed`. The n-bit state and a one-bit serial stream are both available at the outputs.

Top module: `lfsr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, the state is all ones. Reset takes effect asynchronously. After `rst_n` rises, the register first responds to inputs on the third rising clock edge.
- R2: When `en` and `load` are both low, the state does not change.
- R3: When `load` is high and `seed` is nonzero, the state equals `seed` after the next edge. This happens whatever the level of `en`, because load has priority over stepping.
- R4: When `load` is high and `seed` is zero, the state becomes all ones after the next edge. The register never enters the all-zero lock-up state this way.
- R5: External-XOR form (`FORM` = `FORM_EXT`): each step shifts the state toward bit 0. The new bit `WIDTH-1` is the XOR of every bit k whose coefficient ck is one, for k from 0 to `WIDTH-1`.
- R6: Internal-XOR form (`FORM` = `FORM_INT`): each step shifts the state toward bit `WIDTH-1`. The new bit 0 is c0 AND the old top bit. Each new bit k ≥ 1 is the old bit k-1 XOR (ck AND the old top bit).
- R7: With `RECIPROCAL` set, the coefficients used are c*k = c(n-k), with c*0 = 1. The next-state rules of R5 and R6 apply to these coefficients unchanged.
- R8: With `WIDTH` = 3 and coefficients c0 = c1 = 1, c2 = 0 (P(x) = 1 + x + x^3), the external form steps from the all-ones state through 7, 3, 1, 4, 2, 5, 6 and then repeats.
- R9: For a primitive polynomial, in every form, the state returns to its start after exactly 2^WIDTH − 1 steps, visits that many distinct states, and is never zero.
- R10: `serial_out` is state bit 0 in the external form and state bit `WIDTH-1` in the internal form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Write `seed` into the register (all ones if `seed` is zero) |
| seed | input | WIDTH | Starting value for a load |
| state | output | WIDTH | Parallel register state |
| serial_out | output | 1 | Serial output bit |

## Verification
The bench builds all four structures at `WIDTH` = 3 from 1 + x + x^3. This makes the literal seven-state sequence, the reciprocal taps and both serial bit positions directly observable, and a full period can be checked by listing every state. It also builds two 8-bit instances, one in the external form from x^8 + x^4 + x^3 + x^2 + 1 and one in the internal form from that polynomial's reciprocal. These confirm the 255-state period when the tap positions are sparse and lie away from the ends of the chain. A behavioural model in the bench computes the internal form as multiplication by x modulo the polynomial. It derives the reciprocal by bit reversal, so it does not mirror the gate-level structure of the RTL.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic {
    FORM_EXT = 1'b0,
    FORM_INT = 1'b1
  } lfsr_form_e;

  localparam int MAX_ORDER = 64;

  // Coefficient vector of x^n * P(1/x), low n terms; c*0 comes from cn = 1
  function automatic logic [MAX_ORDER-1:0] recip_coeffs(
    input logic [MAX_ORDER-1:0] coeffs,
    input int                   order
  );
    logic [MAX_ORDER-1:0] r;
    r    = '0;
    r[0] = 1'b1;
    for (int k = 1; k < MAX_ORDER; k++) begin
      if (k < order) r[k] = coeffs[order-k];
    end
    return r;
  endfunction

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/lfsr_ext_next.sv
module lfsr_ext_next #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = '1
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt,
  output logic             ser
);

  logic [WIDTH-1:0] term;
  logic             fb;

  // One AND term per coefficient; zero coefficients reduce to constants
  for (genvar k = 0; k < WIDTH; k++) begin : g_term
    if (TAPS[k]) begin : g_on
      assign term[k] = cur[k];
    end else begin : g_off
      assign term[k] = 1'b0;
    end
  end

  assign fb  = ^term;
  assign nxt = {fb, cur[WIDTH-1:1]};
  assign ser = cur[0];

endmodule

// File: rtl/lfsr_int_next.sv
module lfsr_int_next #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = '1
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt,
  output logic             ser
);

  logic msb;

  assign msb = cur[WIDTH-1];

  if (TAPS[0]) begin : g_b0_on
    assign nxt[0] = msb;
  end else begin : g_b0_off
    assign nxt[0] = 1'b0;
  end

  // Single XOR between stages wherever a coefficient is set
  for (genvar k = 1; k < WIDTH; k++) begin : g_stage
    if (TAPS[k]) begin : g_xor
      assign nxt[k] = cur[k-1] ^ msb;
    end else begin : g_wire
      assign nxt[k] = cur[k-1];
    end
  end

  assign ser = msb;

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int                  WIDTH      = 8,
  parameter logic [WIDTH-1:0]    TAPS       = 8'h1D,
  parameter lfsr_pkg::lfsr_form_e FORM      = lfsr_pkg::FORM_EXT,
  parameter bit                  RECIPROCAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state,
  output logic             serial_out
);

  localparam logic [lfsr_pkg::MAX_ORDER-1:0] RECIP_FULL =
    lfsr_pkg::recip_coeffs(lfsr_pkg::MAX_ORDER'(TAPS), WIDTH);
  localparam logic [WIDTH-1:0] EFF_TAPS =
    RECIPROCAL ? RECIP_FULL[WIDTH-1:0] : TAPS;
  localparam logic [WIDTH-1:0] ONES = '1;

  logic             rst_sync_n;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] step_val;
  logic             step_ser;

  lfsr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  if (FORM == lfsr_pkg::FORM_EXT) begin : g_ext
    lfsr_ext_next #(.WIDTH(WIDTH), .TAPS(EFF_TAPS)) u_next (
      .cur (state_q),
      .nxt (step_val),
      .ser (step_ser)
    );
  end else begin : g_int
    lfsr_int_next #(.WIDTH(WIDTH), .TAPS(EFF_TAPS)) u_next (
      .cur (state_q),
      .nxt (step_val),
      .ser (step_ser)
    );
  end

  always_comb begin
    state_d = state_q;
    if (load) begin
      state_d = (seed == '0) ? ONES : seed;
    end else if (en) begin
      state_d = step_val;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ONES;
    end else begin
      state_q <= state_d;
    end
  end

  assign state      = state_q;
  assign serial_out = step_ser;

endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk #(
  parameter int WIDTH = 8,
  parameter bit EXT   = 1'b1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             en,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic [WIDTH-1:0] state,
  input logic             serial_out
);

  // R9
  nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state != '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en && !load) |=> $stable(state));

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && seed != '0) |=> state == $past(seed));

  // R4
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && seed == '0) |=> state == {WIDTH{1'b1}});

  if (EXT) begin : g_ext
    // R5
    ext_shift_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (en && !load) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));
    // R10
    ext_serial_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (en && !load) |=> serial_out == $past(state[1]));
  end else begin : g_int
    // R6
    int_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (en && !load) |=> state[0] == $past(state[WIDTH-1]));
  end

endmodule

bind lfsr_gen lfsr_gen_chk #(
  .WIDTH (WIDTH),
  .EXT   (FORM == lfsr_pkg::FORM_EXT)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .en         (en),
  .load       (load),
  .seed       (seed),
  .state      (state),
  .serial_out (serial_out)
);

// File: tb/lfsr_gen_test.sv
module lfsr_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n;
  logic       en;
  logic       load;
  logic [7:0] seed;

  logic [2:0] s0, s1, s2, s3;
  logic [7:0] s4, s5;
  logic       o0, o1, o2, o3, o4, o5;

  lfsr_gen #(.WIDTH(3), .TAPS(3'b011), .FORM(lfsr_pkg::FORM_EXT), .RECIPROCAL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed[2:0]), .state(s0), .serial_out(o0));
  lfsr_gen #(.WIDTH(3), .TAPS(3'b011), .FORM(lfsr_pkg::FORM_EXT), .RECIPROCAL(1'b1)) uut_er (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed[2:0]), .state(s1), .serial_out(o1));
  lfsr_gen #(.WIDTH(3), .TAPS(3'b011), .FORM(lfsr_pkg::FORM_INT), .RECIPROCAL(1'b0)) uut_ip (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed[2:0]), .state(s2), .serial_out(o2));
  lfsr_gen #(.WIDTH(3), .TAPS(3'b011), .FORM(lfsr_pkg::FORM_INT), .RECIPROCAL(1'b1)) uut_ir (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed[2:0]), .state(s3), .serial_out(o3));
  lfsr_gen #(.WIDTH(8), .TAPS(8'h1D), .FORM(lfsr_pkg::FORM_EXT), .RECIPROCAL(1'b0)) uut_e8 (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .state(s4), .serial_out(o4));
  lfsr_gen #(.WIDTH(8), .TAPS(8'h1D), .FORM(lfsr_pkg::FORM_INT), .RECIPROCAL(1'b1)) uut_i8 (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .seed(seed), .state(s5), .serial_out(o5));

  // Per-instance description: width, form, full polynomial including x^n
  int    wid  [NI] = '{3, 3, 3, 3, 8, 8};
  bit    extf [NI] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  int    base [NI] = '{11, 11, 11, 11, 'h11D, 'h11D};
  bit    rcp  [NI] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  string tag  [NI] = '{"R5", "R7", "R6", "R7", "R5", "R7"};

  int         poly [NI];
  int         mdl  [NI];
  logic [7:0] st   [NI];
  logic       ser  [NI];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always_comb begin
    st[0] = {5'b0, s0}; st[1] = {5'b0, s1}; st[2] = {5'b0, s2};
    st[3] = {5'b0, s3}; st[4] = s4;         st[5] = s5;
    ser[0] = o0; ser[1] = o1; ser[2] = o2; ser[3] = o3; ser[4] = o4; ser[5] = o5;
  end

  function automatic int ones(input int n);
    return (1 << n) - 1;
  endfunction

  function automatic int reverse_poly(input int p, input int n);
    int r = 0;
    for (int k = 0; k <= n; k++) if ((p >> k) & 1) r |= 1 << (n - k);
    return r;
  endfunction

  // External form as a recurrence; internal form as multiplication by x mod P
  function automatic int step(input bit e, input int n, input int p, input int v);
    int t;
    if (e) begin
      t = $countones(v & p & ones(n)) % 2;
      return (v >> 1) | (t << (n - 1));
    end
    t = v << 1;
    if ((t >> n) & 1) t = t ^ p;
    return t;
  endfunction

  initial begin
    for (int i = 0; i < NI; i++)
      poly[i] = rcp[i] ? reverse_poly(base[i], wid[i]) : base[i];
  end

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < NI; i++) begin
      if (!rst_n) mdl[i] <= ones(wid[i]);
      else if (load) mdl[i] <= ((int'(seed) & ones(wid[i])) == 0) ? ones(wid[i]) : (int'(seed) & ones(wid[i]));
      else if (en) mdl[i] <= step(extf[i], wid[i], poly[i], mdl[i]);
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    int es;
    for (int i = 0; i < NI; i++) begin
      check(tag[i], $sformatf("state of instance %0d", i), int'(st[i]), mdl[i]);
      es = extf[i] ? (mdl[i] & 1) : ((mdl[i] >> (wid[i] - 1)) & 1);
      check("R10", $sformatf("serial of instance %0d", i), int'(ser[i]), es);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  int seq3 [8] = '{7, 3, 1, 4, 2, 5, 6, 7};
  int period  [NI];
  int distinct[NI];
  bit zero_hit[NI];
  bit [255:0] seen [NI];

  initial begin
    rst_n = 1'b0; en = 1'b0; load = 1'b0; seed = 8'h00;
    repeat (3) tick();
    // R1: reset value
    for (int i = 0; i < NI; i++) check("R1", "reset state", int'(st[i]), ones(wid[i]));
    rst_n = 1'b1;
    repeat (3) tick();
    for (int i = 0; i < NI; i++) check("R1", "state after release", int'(st[i]), ones(wid[i]));

    // Free run: period and literal sequence
    for (int i = 0; i < NI; i++) begin
      period[i] = 0; distinct[i] = 0; zero_hit[i] = 1'b0; seen[i] = '0;
    end
    en = 1'b1;
    for (int c = 0; c < 260; c++) begin
      if (c < 8) check("R8", $sformatf("sequence step %0d", c), int'(st[0]), seq3[c]);
      for (int i = 0; i < NI; i++) begin
        if (st[i] == 8'h00) zero_hit[i] = 1'b1;
        if (period[i] == 0) begin
          if (c > 0 && int'(st[i]) == ones(wid[i])) period[i] = c;
          else if (!seen[i][st[i]]) begin
            seen[i][st[i]] = 1'b1;
            distinct[i]++;
          end
        end
      end
      tick();
    end
    for (int i = 0; i < NI; i++) begin
      check("R9", $sformatf("period of instance %0d", i), period[i], ones(wid[i]));
      check("R9", $sformatf("distinct states of instance %0d", i), distinct[i], ones(wid[i]));
      check("R9", $sformatf("zero state of instance %0d", i), int'(zero_hit[i]), 0);
    end

    // R2: hold with enable low
    en = 1'b0;
    tick();
    for (int i = 0; i < NI; i++) mdl_snapshot[i] = int'(st[i]);
    repeat (4) tick();
    for (int i = 0; i < NI; i++) check("R2", "held state", int'(st[i]), mdl_snapshot[i]);

    // R3: load with enable low, then load over enable
    seed = 8'hA5; load = 1'b1;
    tick();
    for (int i = 0; i < NI; i++) check("R3", "seed load", int'(st[i]), 'hA5 & ones(wid[i]));
    seed = 8'h3A; en = 1'b1;
    tick();
    for (int i = 0; i < NI; i++) check("R3", "load priority", int'(st[i]), 'h3A & ones(wid[i]));
    load = 1'b0;
    repeat (5) tick();

    // R4: zero seed
    seed = 8'h00; load = 1'b1; en = 1'b0;
    tick();
    for (int i = 0; i < NI; i++) check("R4", "zero seed", int'(st[i]), ones(wid[i]));
    // 3-bit zero seed while the 8-bit seed is nonzero
    seed = 8'h58;
    tick();
    for (int i = 0; i < 4; i++) check("R4", "zero low seed", int'(st[i]), 7);
    check("R3", "wide seed load", int'(st[4]), 'h58);
    load = 1'b0; en = 1'b1;
    repeat (6) tick();

    // R1: asynchronous reset in the middle of a run
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NI; i++) check("R1", "async reset", int'(st[i]), ones(wid[i]));
    en = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    en = 1'b1;
    repeat (10) tick();
    finish_up();
  end

  int mdl_snapshot [NI];

endmodule